// File: doc/BRIEF.md
# Light Level Window Interrupt with Persistence Filter

This block watches the stream of results from a light-sensing converter and raises an interrupt when the light level stays outside a programmable window for long enough. Each result arrives with a one-cycle done strobe. The block compares it against a 16-bit lower limit and a 16-bit upper limit, and each limit is presented as two byte halves. It counts how many results in a row landed outside the window. When that count reaches the length selected by a 2-bit persistence code, it sets a sticky status flag and pulls the open-drain interrupt line low.

The flag holds through any number of later conversions, which keep being compared and counted. It drops only when the register interface pulses the clear strobe, which the register file issues after a host read of the command register finishes. Register storage and the serial bus are outside this block. The reset values of the limits (lower 0x0000, upper 0xFFFF) are held by the register file and only arrive here as input values.

Top module: `lux_window_irq`

## Requirements
- R1: A result counts as out of window when it is less than or equal to the lower limit, or greater than or equal to the upper limit. A result strictly between the two limits is in window.
- R2: The persistence code selects the run length. Code 2'b00 needs 1 consecutive out-of-window result, 2'b01 needs 4, 2'b10 needs 8 and 2'b11 needs 16. The interrupt triggers on the done strobe that completes the run.
- R3: An in-window result sets the run count back to zero, so a full new run is needed before a trigger.
- R4: After a triggering done strobe, the clock edge that samples it sets `irq_sts_o` to 1 and drives `irq_no` to 0. `irq_no` is always the inverse of `irq_sts_o`.
- R5: Once set, the status flag and the pin stay asserted through later conversions, whether they are in or out of window, until a clear strobe arrives.
- R6: A clear strobe with no trigger in the same cycle sets the flag to 0 and releases the pin at the next edge. The run count restarts from zero, and a conversion that arrives in the clear cycle counts as the first of a new run.
- R7: If a clear strobe and a trigger fall in the same cycle, the trigger wins and the flag stays 1.
- R8: Only cycles with the done strobe high advance the run count. Out-of-window data without a done strobe has no effect.
- R9: A change of the persistence code sets the run count back to zero. A conversion in the cycle of the change counts as the first of a new run under the new code.
- R10: The lower limit is formed as {high byte, low byte} from its two byte inputs, and the upper limit is formed the same way.
- R11: After reset, `irq_sts_o` is 0 and `irq_no` is 1 (released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | One-cycle strobe: a new conversion result is valid |
| conv_data_i | input | 16 | Conversion result |
| lo_lsb_i | input | 8 | Lower limit, low byte |
| lo_msb_i | input | 8 | Lower limit, high byte |
| hi_lsb_i | input | 8 | Upper limit, low byte |
| hi_msb_i | input | 8 | Upper limit, high byte |
| persist_i | input | 2 | Persistence code (run length select) |
| clear_i | input | 1 | One-cycle clear strobe from the register interface |
| irq_sts_o | output | 1 | Sticky interrupt status flag for read-back |
| irq_no | output | 1 | Interrupt pin level: 0 pulls low, 1 releases |

## Verification
Two events can fall in the same cycle here: the clear strobe from a finished command-register read, and a done strobe whose out-of-window result completes a run. Directed steps provoke this overlap in two ways. First, with code 2'b00 a clear is issued together with an out-of-window conversion, so the flag must stay set. Second, with code 2'b01 a clear is issued on the fourth result of a run, so the flag must drop because the clear discards the earlier three results. The random phase also mixes frequent clears with done strobes. After every edge, the flag and the pin are compared with a bench model built from the stated priority rules.

// File: rtl/lwi_pkg.sv
`timescale 1ns/1ps
package lwi_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned RUN_MAX = 16;
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);

  typedef logic [1:0]       persist_t;
  typedef logic [RUN_W-1:0] run_t;

  // 00 -> 1, 01 -> 4, 10 -> 8, 11 -> 16
  function automatic run_t run_need(persist_t code);
    if (code == 2'b00) return run_t'(1);
    return run_t'(1) << (run_t'(code) + run_t'(1));
  endfunction
endpackage

// File: rtl/lwi_window.sv
`timescale 1ns/1ps
module lwi_window #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         out_o
);
  // both limits count as outside
  assign out_o = (data_i <= lo_i) || (data_i >= hi_i);
endmodule

// File: rtl/lwi_run_cnt.sv
`timescale 1ns/1ps
module lwi_run_cnt
  import lwi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     done_i,
  input  logic     out_i,
  input  logic     clr_i,
  input  persist_t code_i,
  output logic     trig_o
);
  run_t     cnt_q, cnt_d, base, need;
  persist_t code_q;
  logic     chg;

  assign need = run_need(code_i);
  assign chg  = (code_i != code_q);
  // clear or code change discards the run so far
  assign base = (clr_i || chg) ? '0 : cnt_q;

  always_comb begin
    cnt_d = base;
    if (done_i) begin
      if (!out_i)                      cnt_d = '0;
      else if (base < run_t'(RUN_MAX)) cnt_d = base + run_t'(1);
    end
  end

  assign trig_o = done_i && out_i && ((base + run_t'(1)) >= need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      code_q <= code_i;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= run_t'(RUN_MAX)); // R2
  AST_IN_WINDOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !out_i) |=> (cnt_q == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !clr_i && (code_i == code_q)) |=> $stable(cnt_q)); // R8
  AST_CODE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i != code_q) |=> (cnt_q <= run_t'(1))); // R9
endmodule

// File: rtl/lwi_flag.sv
`timescale 1ns/1ps
module lwi_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic clr_i,
  output logic sts_o,
  output logic irq_no
);
  logic sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sts_q <= 1'b0;
    else if (trig_i) sts_q <= 1'b1; // trigger beats clear
    else if (clr_i)  sts_q <= 1'b0;
  end

  assign sts_o  = sts_q;
  assign irq_no = ~sts_q;

  AST_TRIG_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> sts_q); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !trig_i) |=> !sts_q); // R6
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !clr_i) |=> sts_q); // R5
  AST_ROSE_NEEDS_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q) |-> $past(trig_i)); // R4
endmodule

// File: rtl/lux_window_irq.sv
`timescale 1ns/1ps
module lux_window_irq
  import lwi_pkg::*;
#(
  parameter int unsigned DW = lwi_pkg::DATA_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            conv_done_i,
  input  logic [DW-1:0]   conv_data_i,
  input  logic [DW/2-1:0] lo_lsb_i,
  input  logic [DW/2-1:0] lo_msb_i,
  input  logic [DW/2-1:0] hi_lsb_i,
  input  logic [DW/2-1:0] hi_msb_i,
  input  logic [1:0]      persist_i,
  input  logic            clear_i,
  output logic            irq_sts_o,
  output logic            irq_no
);
  localparam int unsigned BW = DW / 2;

  logic [DW-1:0] lo_thr, hi_thr;
  logic          out_win, trig;

  assign lo_thr = {lo_msb_i, lo_lsb_i};
  assign hi_thr = {hi_msb_i, hi_lsb_i};

  lwi_window #(.W(DW)) i_window (
    .data_i (conv_data_i),
    .lo_i   (lo_thr),
    .hi_i   (hi_thr),
    .out_o  (out_win)
  );

  lwi_run_cnt i_run_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (conv_done_i),
    .out_i  (out_win),
    .clr_i  (clear_i),
    .code_i (persist_i),
    .trig_o (trig)
  );

  lwi_flag i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig),
    .clr_i  (clear_i),
    .sts_o  (irq_sts_o),
    .irq_no (irq_no)
  );

  AST_PIN_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no != irq_sts_o); // R4
  AST_DONE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_sts_o) |-> $past(conv_done_i)); // R8
  AST_BYTE_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !clear_i && (conv_data_i > lo_thr) && (conv_data_i < hi_thr) && !irq_sts_o)
      |=> !irq_sts_o); // R1
endmodule

// File: tb/test_lux_window_irq.sv
`timescale 1ns/1ps
module test_lux_window_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done = 1'b0;
  logic [15:0] data = '0;
  logic [15:0] lo = 16'h0000, hi = 16'hFFFF;
  logic [1:0]  code = 2'b00;
  logic        clr = 1'b0;
  logic        sts, irq_n;

  int checks = 0, errors = 0;
  int m_cnt = 0, m_code = 0;
  bit m_sts = 0, finished = 0;

  always #4 clk = ~clk;

  lux_window_irq i_lux_window_irq (
    .clk_i(clk), .rst_ni(rst_n), .conv_done_i(done), .conv_data_i(data),
    .lo_lsb_i(lo[7:0]), .lo_msb_i(lo[15:8]), .hi_lsb_i(hi[7:0]), .hi_msb_i(hi[15:8]),
    .persist_i(code), .clear_i(clr), .irq_sts_o(sts), .irq_no(irq_n)
  );

  function automatic int need_of(int c);
    return (c == 0) ? 1 : (1 << (c + 1));
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive, update model, sample 2 ns after the edge
  task automatic cyc(input logic d, input logic [15:0] v, input logic c, input string tag);
    int base; bit out_w, trig;
    done = d; data = v; clr = c;
    @(posedge clk);
    base  = (c || int'(code) != m_code) ? 0 : m_cnt;
    out_w = d && (v <= lo || v >= hi);
    trig  = out_w && (base + 1 >= need_of(int'(code)));
    m_cnt = !d ? base : (!out_w ? 0 : (base < 16 ? base + 1 : 16));
    m_code = int'(code);
    if (trig) m_sts = 1; else if (c) m_sts = 0;
    #2;
    chk(sts, m_sts, tag);
    chk(irq_n, !m_sts, tag);
    done = 1'b0; clr = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd2024);
    #20; rst_n = 1'b1;
    @(negedge clk);
    chk(sts, 1'b0, "R11 reset status");
    chk(irq_n, 1'b1, "R11 reset pin");

    // default limits: 0 and FFFF sit on the limits
    cyc(1, 16'h0000, 0, "R1 zero at lower limit 0");
    cyc(0, 16'h0, 1, "R6 clear");
    cyc(1, 16'hFFFF, 0, "R1 FFFF at upper limit");
    cyc(0, 16'h0, 1, "R6 clear");
    cyc(1, 16'h1234, 0, "R1 inside default window");

    lo = 16'h1000; hi = 16'h2000; // R10 byte assembly
    cyc(1, 16'h1001, 0, "R10 just above lower");
    cyc(1, 16'h1FFF, 0, "R10 just below upper");
    cyc(1, 16'h1000, 0, "R1 equal lower fires");
    chk(irq_n, 1'b0, "R4 pin low");
    cyc(1, 16'h1500, 0, "R5 held through in-window");
    cyc(0, 16'h0, 1, "R6 clear releases");
    cyc(1, 16'h2000, 0, "R1 equal upper fires");
    cyc(0, 16'h0, 1, "R6 clear");

    // R8: out-of-window data without done
    for (int i = 0; i < 5; i++) cyc(0, 16'h0005, 0, "R8 no done no effect");

    // R2/R3 with run length 4
    code = 2'b01;
    cyc(0, 16'h0, 0, "R9 code change");
    for (int i = 0; i < 3; i++) cyc(1, 16'h0100, 0, "R2 run below 4");
    cyc(1, 16'h1800, 0, "R3 in-window breaks run");
    for (int i = 0; i < 3; i++) cyc(1, 16'hF000, 0, "R3 restart run");
    cyc(1, 16'hF000, 0, "R2 fourth fires");
    chk(sts, 1'b1, "R2 run of 4 set");

    // R6: clear on 4th result discards earlier three
    cyc(0, 16'h0, 1, "R6 clear");
    for (int i = 0; i < 3; i++) cyc(1, 16'h0100, 0, "R6 partial run");
    cyc(1, 16'h0100, 1, "R6 clear drops run");
    chk(sts, 1'b0, "R6 clear beats stale run");

    // R7: same-cycle clear and trigger
    code = 2'b00;
    cyc(1, 16'h0100, 1, "R7 trigger wins over clear");
    chk(sts, 1'b1, "R7 stays set");
    cyc(0, 16'h0, 1, "R6 clear");

    // R9: code change mid-run
    code = 2'b10;
    for (int i = 0; i < 7; i++) cyc(1, 16'h0100, 0, "R2 run of 8 partial");
    code = 2'b11;
    for (int i = 0; i < 15; i++) cyc(1, 16'h0100, 0, "R9 run restarts under 16");
    cyc(1, 16'h0100, 0, "R2 sixteenth fires");
    chk(sts, 1'b1, "R2 run of 16 set");
    cyc(0, 16'h0, 1, "R6 clear");

    // random mix near the limits
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] v;
      case ($urandom % 4)
        0: v = lo + 16'($urandom % 3) - 16'd1;
        1: v = hi + 16'($urandom % 3) - 16'd1;
        2: v = 16'($urandom);
        default: v = 16'h1800;
      endcase
      if ($urandom % 60 == 0) code = 2'($urandom);
      cyc(($urandom % 2) == 0, v, ($urandom % 12) == 0, "R2 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule